// File: doc/BRIEF.md
# SPI Interrupt Aggregation Unit

This unit gathers the interrupt events raised by the channels of a four-channel SPI master and merges them into one level-sensitive interrupt line. Each channel sends two single-cycle event pulses, one when its transmit holding register empties and one when its receive register fills. Each pulse sets a sticky bit in a status register. Software reads that register to find out which events happened and clears them by writing ones. An enable register picks which status bits drive the interrupt line. The line is registered, so it follows the masked status one clock later.

A small test facility lets software raise every implemented status bit at once, to check the interrupt path without any channel traffic. The facility is armed by a test bit in the mode register together with a force bit in the test register. While both bits are set, software cannot clear status bits. A one-bit wakeup enable is stored for a neighbouring power block and has no other effect here.

Software reaches the registers over a plain 32-bit bus with a word address, a write strobe and a combinational read port.

Top module: `spi_irq_agg`

## Requirements
- R1: After reset the status, enable, test and wakeup registers read 0, the mode register reads 4, and the interrupt output is low.
- R2: A transmit-empty pulse on channel n sets status bit 4n, and a receive-full pulse on channel n sets status bit 4n+2. Bits set this way stay set until they are cleared.
- R3: The interrupt output is high exactly when the AND of status and enable, as it stood on the previous clock, is nonzero.
- R4: Writes to the enable register (word address 1) keep only the bits of mask 0x1777F. The status register never holds a bit outside that mask.
- R5: A write to the status register (word address 0) clears every status bit written as 1 and leaves the other bits unchanged.
- R6: A status write has no effect while mode bit 3 and test bit 11 are both set.
- R7: Writing the test register (word address 3) with bit 11 set, while mode bit 3 is already set, sets every status bit in 0x1777F.
- R8: Writing the mode register (word address 4) with bit 3 set, while test bit 11 is already set, sets every status bit in 0x1777F.
- R9: The test register keeps only bits 11:0 of a write, and the mode register keeps only bits 3:0.
- R10: The wakeup register (word address 2) keeps only bit 0 of a write.
- R11: If an event pulse and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R12: Reads return the register at the word address on the same cycle. Word addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_empty_set | input | 4 | Per-channel transmit-empty event pulse |
| rx_full_set | input | 4 | Per-channel receive-full event pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| irq_o | output | 1 | Registered interrupt line |

## Verification
The hardest cases to reach are the ones where status writes are blocked. To block them, the bench must first leave the test bit stored with the mode bit clear, so that no force happens. It then sets the mode bit, which causes the force, and only then issues the clear that must be ignored. The bench also covers the other force path: it drops the test bit, clears status normally, and writes the test bit again with mode already armed. A same-cycle event pulse and clear on one bit are driven on purpose, and extra random pulses and register accesses are compared on every clock against a behavioural model.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

   typedef enum logic [2:0] {
      RA_STATUS = 3'd0,
      RA_ENABLE = 3'd1,
      RA_WAKE   = 3'd2,
      RA_TEST   = 3'd3,
      RA_MODE   = 3'd4
   } reg_addr_e;

   localparam int          BUS_W          = 32;
   localparam logic [31:0] TEST_KEEP      = 32'h0000_0FFF;
   localparam logic [31:0] MODE_KEEP      = 32'h0000_000F;
   localparam logic [31:0] WAKE_KEEP      = 32'h0000_0001;
   localparam logic [31:0] MODE_RESET     = 32'h0000_0004;
   localparam int          MODE_TEST_BIT  = 3;
   localparam int          TEST_FORCE_BIT = 11;

endpackage

// File: rtl/spi_irq_evt_map.sv
module spi_irq_evt_map
   import spi_irq_pkg::*;
#(
   parameter int          NCH       = 4,
   parameter int          STRIDE    = 4,
   parameter int          TX_OFS    = 0,
   parameter int          RX_OFS    = 2,
   parameter logic [31:0] IMPL_MASK = 32'h0001_777F
) (
   input  logic [NCH-1:0]   tx_evt,
   input  logic [NCH-1:0]   rx_evt,
   output logic [BUS_W-1:0] set_vec
);

   localparam int SPAN = NCH * STRIDE;

   if (SPAN > BUS_W) begin : g_bad_span
      $error("spi_irq_evt_map: channel groups exceed bus width");
   end
   if (TX_OFS >= STRIDE || RX_OFS >= STRIDE || TX_OFS == RX_OFS) begin : g_bad_ofs
      $error("spi_irq_evt_map: bad event offsets");
   end

   logic [BUS_W-1:0] raw;

   for (genvar n = 0; n < NCH; n++) begin : g_ch
      for (genvar b = 0; b < STRIDE; b++) begin : g_bit
         if (b == TX_OFS) begin : g_tx
            assign raw[n*STRIDE+b] = tx_evt[n];
         end else if (b == RX_OFS) begin : g_rx
            assign raw[n*STRIDE+b] = rx_evt[n];
         end else begin : g_idle
            assign raw[n*STRIDE+b] = 1'b0;
         end
      end
   end

   if (SPAN < BUS_W) begin : g_pad
      assign raw[BUS_W-1:SPAN] = '0;
   end

   assign set_vec = raw & IMPL_MASK;

endmodule

// File: rtl/spi_irq_ctrl_regs.sv
module spi_irq_ctrl_regs
   import spi_irq_pkg::*;
#(
   parameter logic [31:0] IMPL_MASK = 32'h0001_777F
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic [2:0]       reg_addr,
   input  logic [BUS_W-1:0] reg_wdata,
   output logic [BUS_W-1:0] enable_q,
   output logic [BUS_W-1:0] wake_q,
   output logic [BUS_W-1:0] test_q,
   output logic [BUS_W-1:0] mode_q,
   output logic [BUS_W-1:0] clr_vec,
   output logic             force_all
);

   logic wr_status, wr_enable, wr_wake, wr_test, wr_mode;
   logic test_locked;

   assign wr_status = reg_we && (reg_addr == RA_STATUS);
   assign wr_enable = reg_we && (reg_addr == RA_ENABLE);
   assign wr_wake   = reg_we && (reg_addr == RA_WAKE);
   assign wr_test   = reg_we && (reg_addr == RA_TEST);
   assign wr_mode   = reg_we && (reg_addr == RA_MODE);

   assign test_locked = mode_q[MODE_TEST_BIT] && test_q[TEST_FORCE_BIT];

   assign clr_vec = (wr_status && !test_locked) ? (reg_wdata & IMPL_MASK) : '0;

   assign force_all = (wr_test && mode_q[MODE_TEST_BIT] && reg_wdata[TEST_FORCE_BIT])
                   || (wr_mode && test_q[TEST_FORCE_BIT] && reg_wdata[MODE_TEST_BIT]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         enable_q <= '0;
         wake_q   <= '0;
         test_q   <= '0;
         mode_q   <= MODE_RESET;
      end else begin
         if (wr_enable) enable_q <= reg_wdata & IMPL_MASK;
         if (wr_wake)   wake_q   <= reg_wdata & WAKE_KEEP;
         if (wr_test)   test_q   <= reg_wdata & TEST_KEEP;
         if (wr_mode)   mode_q   <= reg_wdata & MODE_KEEP;
      end
   end

endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
   import spi_irq_pkg::*;
#(
   parameter logic [31:0] IMPL_MASK = 32'h0001_777F,
   parameter bit          REG_IRQ   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [BUS_W-1:0] set_vec,
   input  logic [BUS_W-1:0] clr_vec,
   input  logic             force_all,
   input  logic [BUS_W-1:0] enable_q,
   output logic [BUS_W-1:0] status_q,
   output logic             irq_o
);

   logic [BUS_W-1:0] status_d;
   logic             pending;

   // set and force are applied after the clear, so an event wins a race
   always_comb begin
      status_d = status_q & ~clr_vec;
      status_d = status_d | set_vec;
      if (force_all) status_d = status_d | IMPL_MASK;
      status_d = status_d & IMPL_MASK;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) status_q <= '0;
      else        status_q <= status_d;
   end

   assign pending = |(status_q & enable_q);

   if (REG_IRQ) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= pending;
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = pending;
   end

endmodule

// File: rtl/spi_irq_agg.sv
module spi_irq_agg
   import spi_irq_pkg::*;
#(
   parameter int          NCH       = 4,
   parameter int          STRIDE    = 4,
   parameter int          TX_OFS    = 0,
   parameter int          RX_OFS    = 2,
   parameter logic [31:0] IMPL_MASK = 32'h0001_777F,
   parameter bit          REG_IRQ   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NCH-1:0]   tx_empty_set,
   input  logic [NCH-1:0]   rx_full_set,
   input  logic             reg_we,
   input  logic [2:0]       reg_addr,
   input  logic [BUS_W-1:0] reg_wdata,
   output logic [BUS_W-1:0] reg_rdata,
   output logic             irq_o
);

   logic [BUS_W-1:0] set_vec, clr_vec;
   logic [BUS_W-1:0] status_q, enable_q, wake_q, test_q, mode_q;
   logic             force_all;

   spi_irq_evt_map #(
      .NCH(NCH), .STRIDE(STRIDE), .TX_OFS(TX_OFS), .RX_OFS(RX_OFS),
      .IMPL_MASK(IMPL_MASK)
   ) u_map (
      .tx_evt (tx_empty_set),
      .rx_evt (rx_full_set),
      .set_vec(set_vec)
   );

   spi_irq_ctrl_regs #(.IMPL_MASK(IMPL_MASK)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_we   (reg_we),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .enable_q (enable_q),
      .wake_q   (wake_q),
      .test_q   (test_q),
      .mode_q   (mode_q),
      .clr_vec  (clr_vec),
      .force_all(force_all)
   );

   spi_irq_status #(.IMPL_MASK(IMPL_MASK), .REG_IRQ(REG_IRQ)) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_vec  (set_vec),
      .clr_vec  (clr_vec),
      .force_all(force_all),
      .enable_q (enable_q),
      .status_q (status_q),
      .irq_o    (irq_o)
   );

   always_comb begin
      case (reg_addr)
         RA_STATUS: reg_rdata = status_q;
         RA_ENABLE: reg_rdata = enable_q;
         RA_WAKE:   reg_rdata = wake_q;
         RA_TEST:   reg_rdata = test_q;
         RA_MODE:   reg_rdata = mode_q;
         default:   reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/spi_irq_agg_chk.sv
module spi_irq_agg_chk
   import spi_irq_pkg::*;
#(
   parameter logic [31:0] IMPL_MASK = 32'h0001_777F,
   parameter bit          REG_IRQ   = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_we,
   input logic [2:0]       reg_addr,
   input logic [BUS_W-1:0] reg_wdata,
   input logic [BUS_W-1:0] set_vec,
   input logic [BUS_W-1:0] status_q,
   input logic [BUS_W-1:0] enable_q,
   input logic [BUS_W-1:0] test_q,
   input logic [BUS_W-1:0] mode_q,
   input logic             irq_o
);

   logic locked;
   assign locked = mode_q[MODE_TEST_BIT] && test_q[TEST_FORCE_BIT];

   a_r3_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
      REG_IRQ |=> (irq_o == ((($past(status_q) & $past(enable_q))) != '0)));

   a_r4_status_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_q & ~IMPL_MASK) == '0) && ((enable_q & ~IMPL_MASK) == '0));

   a_r6_locked_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == RA_STATUS && locked)
      |=> ((status_q & $past(status_q)) == $past(status_q)));

   a_r7_test_force: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == RA_TEST && mode_q[MODE_TEST_BIT] && reg_wdata[TEST_FORCE_BIT])
      |=> (status_q == IMPL_MASK));

   a_r8_mode_force: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == RA_MODE && test_q[TEST_FORCE_BIT] && reg_wdata[MODE_TEST_BIT])
      |=> (status_q == IMPL_MASK));

   a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec != '0) |=> ((status_q & $past(set_vec)) == $past(set_vec)));

endmodule

bind spi_irq_agg spi_irq_agg_chk #(.IMPL_MASK(IMPL_MASK), .REG_IRQ(REG_IRQ)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_we   (reg_we),
   .reg_addr (reg_addr),
   .reg_wdata(reg_wdata),
   .set_vec  (set_vec),
   .status_q (status_q),
   .enable_q (enable_q),
   .test_q   (test_q),
   .mode_q   (mode_q),
   .irq_o    (irq_o)
);

// File: tb/spi_irq_agg_tb_top.sv
module spi_irq_agg_tb_top;

   localparam int unsigned MASK = 32'h0001_777F;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  tx_empty_set = '0;
   logic [3:0]  rx_full_set = '0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_o;

   int vectors = 0;
   int errors  = 0;

   // behavioural reference state
   int unsigned m_st = 0, m_en = 0, m_wk = 0, m_ts = 0, m_md = 4;
   bit          m_irq = 0;

   always #10 clk = ~clk;

   spi_irq_agg dut_i (
      .clk(clk), .rst_n(rst_n), .tx_empty_set(tx_empty_set), .rx_full_set(rx_full_set),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq_o(irq_o)
   );

   function automatic int unsigned m_read(input int a);
      case (a)
         0: return m_st;
         1: return m_en;
         2: return m_wk;
         3: return m_ts;
         4: return m_md;
         default: return 0;
      endcase
   endfunction

   task automatic m_update(input bit we, input int a, input int unsigned wd,
                           input bit [3:0] tx, input bit [3:0] rx);
      int unsigned setv = 0, clr = 0;
      bit frc = 0;
      bit nirq = (m_st & m_en) != 0;
      for (int n = 0; n < 4; n++) begin
         if (tx[n]) setv |= 32'd1 << (4*n);
         if (rx[n]) setv |= 32'd1 << (4*n+2);
      end
      setv &= MASK;
      if (we) begin
         case (a)
            0: if (!(m_md[3] && m_ts[11])) clr = wd & MASK;
            1: m_en = wd & MASK;
            2: m_wk = wd & 1;
            3: begin if (m_md[3] && wd[11]) frc = 1; m_ts = wd & 32'hFFF; end
            4: begin if (m_ts[11] && wd[3]) frc = 1; m_md = wd & 32'hF; end
            default: ;
         endcase
      end
      m_st = ((m_st & ~clr) | setv | (frc ? MASK : 0)) & MASK;
      m_irq = nirq;
   endtask

   task automatic step(input string tag, input bit we, input int a, input int unsigned wd,
                       input bit [3:0] tx, input bit [3:0] rx);
      int unsigned exp_rd;
      @(negedge clk);
      reg_we = we; reg_addr = a[2:0]; reg_wdata = wd;
      tx_empty_set = tx; rx_full_set = rx;
      #1;
      exp_rd = m_read(a);
      vectors++;
      if (reg_rdata !== exp_rd || irq_o !== m_irq) begin
         errors++;
         $display("FAIL %s: addr %0d rdata %h irq %b, expected rdata %h irq %b",
                  tag, a, reg_rdata, irq_o, exp_rd, m_irq);
      end
      @(posedge clk);
      m_update(we, a, wd, tx, rx);
   endtask

   task automatic rd(input string tag, input int a);
      step(tag, 0, a, 0, 4'h0, 4'h0);
   endtask

   task automatic wr(input string tag, input int a, input int unsigned wd);
      step(tag, 1, a, wd, 4'h0, 4'h0);
   endtask

   initial begin
      #(20 * 200000);
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      // R1 reset values, R12 unmapped addresses
      for (int a = 0; a < 8; a++) rd(a < 5 ? "R1" : "R12", a);
      // R2 event pulses per channel
      step("R2", 0, 0, 0, 4'b1001, 4'b0000);
      step("R2", 0, 0, 0, 4'b0000, 4'b0110);
      rd("R2", 0);
      // R4 enable masking, R3 irq one cycle later
      wr("R4", 1, 32'hFFFF_FFFF);
      rd("R4", 1);
      rd("R3", 0);
      rd("R3", 0);
      // R5 write-one-to-clear
      wr("R5", 0, 32'h0000_0001);
      rd("R5", 0);
      // R11 set and clear together
      step("R11", 1, 0, 32'h0000_0010, 4'b0010, 4'b0000);
      rd("R11", 0);
      // R9 register width limits; no force since mode bit 3 is clear
      wr("R9", 3, 32'hFFFF_F800);
      rd("R9", 3);
      rd("R9", 0);
      // R8 force through mode write
      wr("R8", 4, 32'hFFFF_FFFF);
      rd("R9", 4);
      rd("R8", 0);
      // R6 clear blocked while locked
      wr("R6", 0, 32'hFFFF_FFFF);
      rd("R6", 0);
      // drop test bit, clear normally, then R7 force through test write
      wr("R7", 3, 32'h0000_0000);
      wr("R5", 0, 32'hFFFF_FFFF);
      rd("R5", 0);
      wr("R7", 3, 32'h0000_0800);
      rd("R7", 0);
      // R10 wakeup bit
      wr("R10", 2, 32'hFFFF_FFFF);
      rd("R10", 2);
      // R3 irq falls after enable cleared
      wr("R3", 4, 32'h0);
      wr("R3", 1, 32'h0);
      rd("R3", 0);
      rd("R3", 0);
      // mixed traffic
      for (int i = 0; i < 300; i++) begin
         int unsigned v = $urandom;
         step("R2", ($urandom % 3) == 0, $urandom % 8, v,
              4'($urandom), 4'($urandom));
      end
      rd("R3", 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule